// File: doc/BRIEF.md
# Trap Register-Altered Bit Tracker

This block watches the architectural side effects of the instruction in flight and keeps one sticky "register altered" flag for it. When the instruction traps, the flag is merged into the old program status doubleword (PSW) image. Trap software reads that bit and decides whether the faulting instruction can simply be retried.

The flag is cleared when a new instruction starts. The instruction's class and whether it consumes the condition codes are latched at that point. After that, every write strobe that counts for the class sets the flag. Immediate and no-operand instructions cannot take an operand-access trap, so they never set it. A taken branch or execute instruction commits its register only after the target fetch, so register and PSW writes are not counted for it. Condition-code writes count only when the instruction reads the condition codes as inputs.

Top module: `alt_tracker`

## Requirements
- R1: After synchronous reset, `altered`, `trap_psw_vld` and `trap_psw` are all zero.
- R2: A cycle with `insn_start` high starts a new instruction and latches `insn_class` and `cc_is_input`. Only that cycle's strobes count toward the new flag, judged by the new class. `altered` shows the result one cycle later.
- R3: For class GENERAL (`insn_class`=1) or STORE (`insn_class`=2), any of `mem_wr`, `freg_wr` or `psw_wr` sets `altered`.
- R4: `cc_wr` sets `altered` only when the latched `cc_is_input` is 1. Otherwise it has no effect.
- R5: For class NOACCESS (`insn_class`=0), no strobe ever sets `altered`.
- R6: For class BRANCH (`insn_class`=3), `freg_wr` and `psw_wr` are ignored. `mem_wr` still sets the flag, and `cc_wr` follows R4.
- R7: Once set, `altered` stays set until the next `insn_start`, whatever later writes occur. A rollback write does not clear it.
- R8: On `trap`, `trap_psw` is loaded with `old_psw` one cycle later, and `trap_psw_vld` pulses for one cycle. Bit 60 of `trap_psw` is replaced by the accumulated flag, including that cycle's counted strobes. PSW bits are numbered with bit 0 as the MSB, so bit 60 is vector index 3. All other bits pass through unchanged.
- R9: Without `trap`, `trap_psw` holds its value and `trap_psw_vld` is low.
- R10: If `trap` and `insn_start` are high in the same cycle, the capture uses the outgoing instruction's accumulated flag. That cycle's strobes go to the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_start | input | 1 | First cycle of a new instruction |
| insn_class | input | 2 | 0 NOACCESS, 1 GENERAL, 2 STORE, 3 BRANCH; sampled with insn_start |
| cc_is_input | input | 1 | Instruction reads condition codes; sampled with insn_start |
| mem_wr | input | 1 | Main memory write this cycle |
| freg_wr | input | 1 | Fast register write this cycle |
| psw_wr | input | 1 | PSW field or flag write this cycle |
| cc_wr | input | 1 | Condition code write this cycle |
| trap | input | 1 | Trap strobe |
| old_psw | input | 64 | Old PSW image at trap time |
| altered | output | 1 | Accumulated altered flag |
| trap_psw | output | 64 | Captured old PSW with bit 60 merged |
| trap_psw_vld | output | 1 | One-cycle pulse after capture |

## Verification
If the accumulator is wrong or not sticky, `altered` shows it one cycle after the offending strobe or start. The same error appears in bit index 3 of `trap_psw` one cycle after the next trap. If the class or condition-code flag is latched wrongly, the flag rises on a strobe that should be ignored, visible on the next cycle. A wrong merge position or a wrong source choice on a combined trap and start corrupts `trap_psw` in the cycle right after the trap.

// File: rtl/alt_tracker_pkg.sv
package alt_tracker_pkg;

    typedef enum logic [1:0] {
        CLS_NOACC   = 2'd0,
        CLS_GENERAL = 2'd1,
        CLS_STORE   = 2'd2,
        CLS_BRANCH  = 2'd3
    } insn_cls_e;

    typedef struct packed {
        logic mem;
        logic freg;
        logic psw;
        logic cc;
    } wr_strobes_t;

    typedef struct packed {
        insn_cls_e cls;
        logic      cc_in;
    } insn_attr_t;

    // Decide whether this cycle's strobes count as an alteration for the class.
    function automatic logic counts_as_alter(insn_attr_t a, wr_strobes_t s);
        logic cc_hit;
        cc_hit = s.cc && a.cc_in;
        unique case (a.cls)
            CLS_NOACC:   return 1'b0;
            CLS_BRANCH:  return s.mem || cc_hit;
            default:     return s.mem || s.freg || s.psw || cc_hit;
        endcase
    endfunction

endpackage

// File: rtl/alt_event.sv
module alt_event
    import alt_tracker_pkg::*;
(
    input  insn_attr_t  attr,
    input  wr_strobes_t strobes,
    output logic        hit
);
    always_comb hit = counts_as_alter(attr, strobes);
endmodule

// File: rtl/alt_accum.sv
module alt_accum
    import alt_tracker_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  insn_attr_t attr_in,
    input  logic       hit,
    output insn_attr_t attr_q,
    output logic       flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q <= '{cls: CLS_NOACC, cc_in: 1'b0};
            flag_q <= 1'b0;
        end else if (start) begin
            attr_q <= attr_in;
            flag_q <= hit;
        end else begin
            flag_q <= flag_q | hit;
        end
    end
endmodule

// File: rtl/alt_merge.sv
module alt_merge #(
    parameter int PSW_W   = 64,
    parameter int ALT_POS = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap,
    input  logic             flag,
    input  logic [PSW_W-1:0] psw_in,
    output logic [PSW_W-1:0] psw_q,
    output logic             vld_q
);
    // Bit numbering is MSB = 0.
    localparam int IDX = PSW_W - 1 - ALT_POS;

    logic [PSW_W-1:0] merged;

    always_comb begin
        merged      = psw_in;
        merged[IDX] = flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            psw_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= trap;
            if (trap) psw_q <= merged;
        end
    end
endmodule

// File: rtl/alt_tracker.sv
module alt_tracker
    import alt_tracker_pkg::*;
#(
    parameter int PSW_W   = 64,
    parameter int ALT_POS = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_start,
    input  logic [1:0]       insn_class,
    input  logic             cc_is_input,
    input  logic             mem_wr,
    input  logic             freg_wr,
    input  logic             psw_wr,
    input  logic             cc_wr,
    input  logic             trap,
    input  logic [PSW_W-1:0] old_psw,
    output logic             altered,
    output logic [PSW_W-1:0] trap_psw,
    output logic             trap_psw_vld
);
    insn_attr_t  attr_new, attr_q, attr_cur;
    wr_strobes_t strobes;
    logic        hit, flag_q, capture_flag;

    always_comb begin
        attr_new = '{cls: insn_cls_e'(insn_class), cc_in: cc_is_input};
        attr_cur = insn_start ? attr_new : attr_q;
        strobes  = '{mem: mem_wr, freg: freg_wr, psw: psw_wr, cc: cc_wr};
        // Strobes in a start cycle belong to the incoming instruction.
        capture_flag = flag_q | (hit & ~insn_start);
    end

    alt_event u_event (
        .attr    (attr_cur),
        .strobes (strobes),
        .hit     (hit)
    );

    alt_accum u_accum (
        .clk     (clk),
        .rst     (rst),
        .start   (insn_start),
        .attr_in (attr_new),
        .hit     (hit),
        .attr_q  (attr_q),
        .flag_q  (flag_q)
    );

    alt_merge #(.PSW_W(PSW_W), .ALT_POS(ALT_POS)) u_merge (
        .clk    (clk),
        .rst    (rst),
        .trap   (trap),
        .flag   (capture_flag),
        .psw_in (old_psw),
        .psw_q  (trap_psw),
        .vld_q  (trap_psw_vld)
    );

    assign altered = flag_q;
endmodule

// File: rtl/alt_tracker_chk.sv
module alt_tracker_chk #(
    parameter int PSW_W   = 64,
    parameter int ALT_POS = 60
) (
    input logic             clk,
    input logic             rst,
    input logic             insn_start,
    input logic [1:0]       insn_class,
    input logic             mem_wr,
    input logic             freg_wr,
    input logic             psw_wr,
    input logic             cc_wr,
    input logic             trap,
    input logic [PSW_W-1:0] old_psw,
    input logic             altered,
    input logic [PSW_W-1:0] trap_psw,
    input logic             trap_psw_vld
);
    localparam int IDX = PSW_W - 1 - ALT_POS;

    logic [PSW_W-1:0] mask;
    always_comb begin
        mask      = '1;
        mask[IDX] = 1'b0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!altered && !trap_psw_vld && trap_psw == '0));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_start && !(mem_wr || freg_wr || psw_wr || cc_wr)) |=> !altered);

    // R5
    noacc_start_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_start && insn_class == 2'd0) |=> !altered);

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (altered && !insn_start) |=> altered);

    // R8
    trap_vld_chk: assert property (@(posedge clk) disable iff (rst) trap |=> trap_psw_vld);

    // R8
    passthru_chk: assert property (@(posedge clk) disable iff (rst)
        trap |=> ((trap_psw & mask) == ($past(old_psw) & mask)));

    // R8
    merge_set_chk: assert property (@(posedge clk) disable iff (rst)
        (trap && altered) |=> trap_psw[IDX]);

    // R9
    hold_psw_chk: assert property (@(posedge clk) disable iff (rst)
        !trap |=> ($stable(trap_psw) && !trap_psw_vld));
endmodule

bind alt_tracker alt_tracker_chk #(.PSW_W(PSW_W), .ALT_POS(ALT_POS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .insn_start   (insn_start),
    .insn_class   (insn_class),
    .mem_wr       (mem_wr),
    .freg_wr      (freg_wr),
    .psw_wr       (psw_wr),
    .cc_wr        (cc_wr),
    .trap         (trap),
    .old_psw      (old_psw),
    .altered      (altered),
    .trap_psw     (trap_psw),
    .trap_psw_vld (trap_psw_vld)
);

// File: tb/test_alt_tracker.sv
module test_alt_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_start = 1'b0;
    logic [1:0]  insn_class = 2'd0;
    logic        cc_is_input = 1'b0;
    logic        mem_wr = 1'b0, freg_wr = 1'b0, psw_wr = 1'b0, cc_wr = 1'b0;
    logic        trap = 1'b0;
    logic [63:0] old_psw = '0;
    logic        altered;
    logic [63:0] trap_psw;
    logic        trap_psw_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alt_tracker i_alt_tracker (
        .clk(clk), .rst(rst), .insn_start(insn_start), .insn_class(insn_class),
        .cc_is_input(cc_is_input), .mem_wr(mem_wr), .freg_wr(freg_wr),
        .psw_wr(psw_wr), .cc_wr(cc_wr), .trap(trap), .old_psw(old_psw),
        .altered(altered), .trap_psw(trap_psw), .trap_psw_vld(trap_psw_vld)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs were set 1 ns after the previous edge.
    task automatic tick();
        @(posedge clk);
        #1;
        insn_start = 0; mem_wr = 0; freg_wr = 0; psw_wr = 0; cc_wr = 0; trap = 0;
    endtask

    task automatic begin_insn(logic [1:0] cls, logic ccin);
        insn_start = 1; insn_class = cls; cc_is_input = ccin;
        tick();
    endtask

    task automatic t_reset();
        check("R1 altered", {63'd0, altered}, 64'd0);
        check("R1 vld", {63'd0, trap_psw_vld}, 64'd0);
        check("R1 psw", trap_psw, 64'd0);
    endtask

    task automatic t_general();
        for (int k = 0; k < 3; k++) begin
            for (int c = 1; c <= 2; c++) begin
                begin_insn(c[1:0], 1'b0);
                check("R2 cleared", {63'd0, altered}, 64'd0);
                mem_wr = (k == 0); freg_wr = (k == 1); psw_wr = (k == 2);
                tick();
                check("R3 write sets", {63'd0, altered}, 64'd1);
            end
        end
    endtask

    task automatic t_cc();
        begin_insn(2'd1, 1'b0);
        cc_wr = 1; tick();
        check("R4 cc ignored", {63'd0, altered}, 64'd0);
        begin_insn(2'd1, 1'b1);
        cc_wr = 1; tick();
        check("R4 cc counts", {63'd0, altered}, 64'd1);
    endtask

    task automatic t_noacc();
        begin_insn(2'd0, 1'b1);
        mem_wr = 1; freg_wr = 1; psw_wr = 1; cc_wr = 1; tick();
        check("R5 noacc", {63'd0, altered}, 64'd0);
        insn_start = 1; insn_class = 2'd0; cc_is_input = 1; mem_wr = 1; cc_wr = 1; tick();
        check("R5 noacc start cycle", {63'd0, altered}, 64'd0);
    endtask

    task automatic t_branch();
        begin_insn(2'd3, 1'b0);
        freg_wr = 1; psw_wr = 1; cc_wr = 1; tick();
        check("R6 branch reg ignored", {63'd0, altered}, 64'd0);
        mem_wr = 1; tick();
        check("R6 branch mem", {63'd0, altered}, 64'd1);
        begin_insn(2'd3, 1'b1);
        cc_wr = 1; tick();
        check("R6 branch cc used", {63'd0, altered}, 64'd1);
    endtask

    task automatic t_sticky();
        begin_insn(2'd1, 1'b0);
        freg_wr = 1; tick();
        freg_wr = 1; tick();
        tick(); tick();
        check("R7 sticky", {63'd0, altered}, 64'd1);
        begin_insn(2'd1, 1'b0);
        check("R2 start clears", {63'd0, altered}, 64'd0);
        insn_start = 1; insn_class = 2'd2; mem_wr = 1; tick();
        check("R2 start cycle write", {63'd0, altered}, 64'd1);
    endtask

    task automatic t_trap();
        logic [63:0] p;
        p = 64'hA5A5_5A5A_F0F0_0F0F;
        begin_insn(2'd1, 1'b0);
        trap = 1; old_psw = p; tick();
        check("R8 vld", {63'd0, trap_psw_vld}, 64'd1);
        check("R8 clear merge", trap_psw, p & ~64'h8);
        tick();
        check("R9 vld low", {63'd0, trap_psw_vld}, 64'd0);
        old_psw = 64'h0; tick();
        check("R9 hold", trap_psw, p & ~64'h8);
        begin_insn(2'd2, 1'b0);
        mem_wr = 1; trap = 1; old_psw = 64'h0; tick();
        check("R8 same-cycle write", trap_psw, 64'h8);
        begin_insn(2'd1, 1'b0);
        psw_wr = 1; tick();
        trap = 1; old_psw = 64'hFFFF_FFFF_FFFF_FFF7; tick();
        check("R8 set merge", trap_psw, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_trap_start();
        begin_insn(2'd1, 1'b0);
        mem_wr = 1; tick();
        trap = 1; old_psw = 64'h0; insn_start = 1; insn_class = 2'd0; tick();
        check("R10 old flag captured", trap_psw, 64'h8);
        check("R10 new cleared", {63'd0, altered}, 64'd0);
        trap = 1; old_psw = 64'h0; insn_start = 1; insn_class = 2'd1; mem_wr = 1; tick();
        check("R10 new strobe excluded", trap_psw, 64'h0);
        check("R10 new strobe counted", {63'd0, altered}, 64'd1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 0;
        t_general();
        t_cc();
        t_noacc();
        t_branch();
        t_sticky();
        t_trap();
        t_trap_start();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule